// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit register bus. A register changes only when the write carries the key that belongs to that register. Without a key, stray writes from runaway software cannot disarm the watchdog, shorten its timeout or feed it. The down-counter advances on a slow tick enable, nominally 32.768 kHz. The timeout is given in units of `UNIT_TICKS` ticks. With the default of 512 ticks, one unit is 15.625 ms, and the 10-bit length field reaches about 16 s.

Software feeds the watchdog by writing a fixed code to the restart register. If the counter runs out first, the block drives a fixed-width reset pulse at the programmed polarity. In interrupt mode it raises an interrupt instead. In dual mode it raises the interrupt on the first expiry and drives the reset on a second expiry that comes without a restart. A separate software-reset register fires the reset pulse at once. A status register records which event caused the last reset.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the mode register reads 0 (disabled, active-low reset output held at 1), the interrupt output is 0, the status reads 0, and the length reads the maximum count of all ones in bits starting at bit 5.
- R2: A write to offset 0x00 takes effect only if bits 31:24 equal 0x22. Mode bits: bit 0 enable, bit 1 polarity (1 = active-high reset output), bit 2 external reset enable, bit 3 interrupt mode, bit 6 dual mode.
- R3: A write to offset 0x04 takes effect only if bits 4:0 equal 0x08. The count is taken from the `LEN_W` bits starting at bit 5.
- R4: Once reloaded and enabled, the counter expires after `max(length,1) * UNIT_TICKS` cycles in which the tick enable is high. Cycles with the tick enable low do not advance it.
- R5: A write of exactly 0x00001971 to offset 0x08 reloads the counter from the programmed length. Any other value written there has no effect.
- R6: A write of exactly 0x00001209 to offset 0x14 starts the reset pulse at the next clock edge, even while the watchdog is disabled, and sets status bit 1. Any other value is ignored.
- R7: While the enable bit is 0 the counter holds its value and no timeout reset is produced.
- R8: A reset pulse keeps the reset output active for exactly `PULSE_CYC` bus clocks. Active level is high when mode bit 1 is 1 and low otherwise.
- R9: When the external reset enable is 0, a reset-type expiry drives no pulse but still sets status bit 0.
- R10: In interrupt mode without dual mode, every expiry sets the interrupt output and none produces a reset. A restart write clears the interrupt.
- R11: With interrupt and dual mode both set, the first expiry raises the interrupt. A second expiry with no restart in between produces the reset pulse and sets status bit 0.
- R12: Status reads bit 0 = timeout reset, bit 1 = software reset, bit 2 = interrupt pending. Bits 0 and 1 clear only on a keyed mode write.
- R13: Reads return register contents with key fields as zero. Offset 0x10 reads the remaining count in units. Keyed mode and length writes also reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slow watchdog tick enable, one bus cycle wide |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | 32 | Write data including key fields |
| rdData | output | 32 | Read data for `addr`, combinational |
| rstOut | output | 1 | Watchdog reset output, polarity set by mode bit 1 |
| irqOut | output | 1 | Watchdog interrupt, level |

## Verification
The timeout path is run with several lengths, including zero, one and the maximum, each on a free-running tick and on a tick high every other cycle. These runs separate the unit arithmetic from the prescaler gating and from the zero-to-one clamp. Each key is tried with a near-miss value beside the correct one, so that a key that is checked too loosely stands apart from one that is never checked. The expiry modes (plain reset, reset with the output disabled, interrupt, dual) are run with the same length. The outputs and status readback then show which event path was taken.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_LSB = 5;

  localparam logic [7:0] OFF_MODE     = 8'h00;
  localparam logic [7:0] OFF_LEN      = 8'h04;
  localparam logic [7:0] OFF_RESTART  = 8'h08;
  localparam logic [7:0] OFF_STATUS   = 8'h0C;
  localparam logic [7:0] OFF_INTERVAL = 8'h10;
  localparam logic [7:0] OFF_SWRST    = 8'h14;

  localparam logic [7:0]  MODE_KEY     = 8'h22;
  localparam logic [4:0]  LEN_KEY      = 5'h08;
  localparam logic [31:0] RESTART_CODE = 32'h0000_1971;
  localparam logic [31:0] SWRST_CODE   = 32'h0000_1209;

  typedef struct packed {
    logic dual;
    logic irqEn;
    logic extEn;
    logic pol;
    logic en;
  } wdMode_t;

  typedef struct packed {
    logic reload;
    logic swReset;
    logic clrStatus;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  curCnt,
  input  logic              stTimeout,
  input  logic              stSw,
  input  logic              irqPend,
  output wdMode_t           mode,
  output wdStrobe_t         strb,
  output logic [LEN_W-1:0]  loadLen,
  output logic [DATA_W-1:0] rdData
);
  logic hitMode, hitLen, hitRestart, hitSwrst;
  logic modeWr, lenWr, restartWr, swWr;
  wdMode_t modeR;
  logic [LEN_W-1:0] lenR;
  logic [LEN_W-1:0] newLen;

  assign hitMode    = wrEn && (addr == ADDR_W'(OFF_MODE));
  assign hitLen     = wrEn && (addr == ADDR_W'(OFF_LEN));
  assign hitRestart = wrEn && (addr == ADDR_W'(OFF_RESTART));
  assign hitSwrst   = wrEn && (addr == ADDR_W'(OFF_SWRST));

  assign modeWr    = hitMode && (wrData[31:24] == MODE_KEY);
  assign lenWr     = hitLen && (wrData[LEN_LSB-1:0] == LEN_KEY);
  assign restartWr = hitRestart && (wrData == RESTART_CODE);
  assign swWr      = hitSwrst && (wrData == SWRST_CODE);

  assign newLen = wrData[LEN_LSB +: LEN_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR <= '0;
      lenR  <= '1;
    end else begin
      if (modeWr) begin
        modeR.en    <= wrData[0];
        modeR.pol   <= wrData[1];
        modeR.extEn <= wrData[2];
        modeR.irqEn <= wrData[3];
        modeR.dual  <= wrData[6];
      end
      if (lenWr) lenR <= newLen;
    end
  end

  assign mode           = modeR;
  assign loadLen        = lenWr ? newLen : lenR;
  assign strb.reload    = modeWr || lenWr || restartWr;
  assign strb.swReset   = swWr;
  assign strb.clrStatus = modeWr;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(OFF_MODE): begin
        rdData[0] = modeR.en;
        rdData[1] = modeR.pol;
        rdData[2] = modeR.extEn;
        rdData[3] = modeR.irqEn;
        rdData[6] = modeR.dual;
      end
      ADDR_W'(OFF_LEN):      rdData[LEN_LSB +: LEN_W] = lenR;
      ADDR_W'(OFF_STATUS):   rdData[2:0] = {irqPend, stSw, stTimeout};
      ADDR_W'(OFF_INTERVAL): rdData[LEN_W-1:0] = curCnt;
      default:               rdData = '0;
    endcase
  end

  a_r2_mode_key: assert property (@(posedge clk) disable iff (!rstN)
    (hitMode && wrData[31:24] != MODE_KEY) |=> $stable(modeR));

  a_r3_len_key: assert property (@(posedge clk) disable iff (!rstN)
    (hitLen && wrData[LEN_LSB-1:0] != LEN_KEY) |=> $stable(lenR));
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int UNIT_TICKS = 512,
  parameter int PULSE_CYC  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  wdMode_t          mode,
  input  wdStrobe_t        strb,
  input  logic [LEN_W-1:0] loadLen,
  output logic [LEN_W-1:0] curCnt,
  output logic             stTimeout,
  output logic             stSw,
  output logic             irqPend,
  output logic             rstOut,
  output logic             irqOut
);
  localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam int PUL_W = $clog2(PULSE_CYC + 1);

  logic [PRE_W-1:0] presc;
  logic [LEN_W-1:0] cnt;
  logic [PUL_W-1:0] pulseCnt;
  logic [LEN_W-1:0] loadVal;
  logic unitHit, expire, toReset, toIrq, fire, rstActive;

  assign loadVal = (loadLen == '0) ? LEN_W'(1) : loadLen;
  assign unitHit = mode.en && tickEn && !strb.reload &&
                   (presc == PRE_W'(UNIT_TICKS - 1));
  assign expire  = unitHit && (cnt <= LEN_W'(1));
  assign toReset = expire && (!mode.irqEn || (mode.dual && irqPend));
  assign toIrq   = expire && mode.irqEn && !toReset;
  assign fire    = strb.swReset || (toReset && mode.extEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc     <= '0;
      cnt       <= '1;
      pulseCnt  <= '0;
      irqPend   <= 1'b0;
      stTimeout <= 1'b0;
      stSw      <= 1'b0;
    end else begin
      if (strb.reload)             presc <= '0;
      else if (unitHit)            presc <= '0;
      else if (mode.en && tickEn)  presc <= presc + PRE_W'(1);

      if (strb.reload || expire)   cnt <= loadVal;
      else if (unitHit)            cnt <= cnt - LEN_W'(1);

      if (strb.reload)             irqPend <= 1'b0;
      else if (toIrq)              irqPend <= 1'b1;

      if (toReset)                 stTimeout <= 1'b1;
      else if (strb.clrStatus)     stTimeout <= 1'b0;

      if (strb.swReset)            stSw <= 1'b1;
      else if (strb.clrStatus)     stSw <= 1'b0;

      if (fire)                    pulseCnt <= PUL_W'(PULSE_CYC);
      else if (pulseCnt != '0)     pulseCnt <= pulseCnt - PUL_W'(1);
    end
  end

  assign rstActive = (pulseCnt != '0);
  assign rstOut    = mode.pol ? rstActive : !rstActive;
  assign irqOut    = irqPend;
  assign curCnt    = cnt;

  a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0);

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!mode.en && !strb.reload) |=> $stable(cnt));

  a_r6_swrst_immediate: assert property (@(posedge clk) disable iff (!rstN)
    strb.swReset |=> rstActive);

  a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PUL_W'(PULSE_CYC));

  a_r10_irq_first: assert property (@(posedge clk) disable iff (!rstN)
    (expire && mode.irqEn && !irqPend) |=> irqPend);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 10,
  parameter int UNIT_TICKS = 512,
  parameter int PULSE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rstOut,
  output logic              irqOut
);
  wdMode_t          mode;
  wdStrobe_t        strb;
  logic [LEN_W-1:0] loadLen;
  logic [LEN_W-1:0] curCnt;
  logic             stTimeout, stSw, irqPend;

  wdog_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .curCnt(curCnt), .stTimeout(stTimeout), .stSw(stSw), .irqPend(irqPend),
    .mode(mode), .strb(strb), .loadLen(loadLen), .rdData(rdData)
  );

  wdog_dp #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS), .PULSE_CYC(PULSE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .mode(mode), .strb(strb),
    .loadLen(loadLen), .curCnt(curCnt), .stTimeout(stTimeout), .stSw(stSw),
    .irqPend(irqPend), .rstOut(rstOut), .irqOut(irqOut)
  );
endmodule

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
  localparam logic [31:0] MKEY = 32'h2200_0000;
  localparam logic [7:0] A_MODE = 8'h00, A_LEN = 8'h04, A_RST = 8'h08,
                         A_STAT = 8'h0C, A_INT = 8'h10, A_SW = 8'h14;
  // {length[9:0], slowTick, expected edges to expiry}
  localparam logic [26:0] VEC [6] = '{
    {10'd3,    1'b0, 16'd12},
    {10'd0,    1'b0, 16'd4},
    {10'd1,    1'b0, 16'd4},
    {10'd7,    1'b0, 16'd28},
    {10'd2,    1'b1, 16'd15},
    {10'd1023, 1'b0, 16'd4092}
  };

  logic clk = 1'b0;
  logic rstN, tickEn, wrEn;
  logic [7:0] addr;
  logic [31:0] wrData, rdData;
  logic rstOut, irqOut;
  logic slow;
  logic [7:0] ph;
  logic [31:0] rv;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_keyed #(.UNIT_TICKS(4)) u_wdog_keyed (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rstOut(rstOut), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tickSet();
    ph = ph + 8'd1;
    tickEn = slow ? ph[0] : 1'b1;
  endtask

  task automatic waitc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tickSet();
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    tickSet();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    tickEn = 1'b1; slow = 1'b0; ph = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rstOut", {31'd0, rstOut}, 32'd1);
    chk("R1 irqOut", {31'd0, irqOut}, 32'd0);
    rd(A_MODE, rv); chk("R1 mode", rv, 32'd0);
    rd(A_LEN, rv);  chk("R1 length", rv, 32'h7FE0);
    rd(A_STAT, rv); chk("R1 status", rv, 32'd0);

    // R4 table: timeout length, zero clamp, tick gating
    for (int i = 0; i < 6; i++) begin
      wr(A_MODE, MKEY | 32'h2);
      waitc(20);
      wr(A_LEN, ({22'd0, VEC[i][26:17]} << 5) | 32'h8);
      ph = '0;
      slow = VEC[i][16];
      wr(A_MODE, MKEY | 32'h7);
      waitc(int'(VEC[i][15:0]) - 1);
      chk("R4 before expiry", {31'd0, rstOut}, 32'd0);
      waitc(1);
      chk("R4 at expiry", {31'd0, rstOut}, 32'd1);
      slow = 1'b0;
    end
    wr(A_MODE, MKEY | 32'h2);
    waitc(20);

    // R13 readback, R2 / R3 keys
    wr(A_MODE, MKEY | 32'h4);
    rd(A_MODE, rv); chk("R13 mode read", rv, 32'h4);
    wr(A_LEN, (32'd5 << 5) | 32'h8);
    rd(A_LEN, rv); chk("R13 length read", rv, 32'hA0);
    rd(A_INT, rv); chk("R13 interval", rv, 32'd5);
    wr(A_MODE, 32'h2300_0001);
    rd(A_MODE, rv); chk("R2 bad key", rv, 32'h4);
    wr(A_LEN, (32'd9 << 5) | 32'h9);
    rd(A_LEN, rv); chk("R3 bad key", rv, 32'hA0);

    // R7 disabled: no progress
    waitc(100);
    chk("R7 no reset", {31'd0, rstOut}, 32'd1);
    rd(A_INT, rv); chk("R7 count held", rv, 32'd5);

    // R8 active-low pulse width
    wr(A_MODE, MKEY | 32'h5);
    waitc(19); chk("R8 idle high", {31'd0, rstOut}, 32'd1);
    waitc(1);  chk("R8 pulse low", {31'd0, rstOut}, 32'd0);
    waitc(15); chk("R8 last pulse cycle", {31'd0, rstOut}, 32'd0);
    waitc(1);  chk("R8 pulse end", {31'd0, rstOut}, 32'd1);
    wr(A_MODE, MKEY | 32'h2);
    waitc(20);

    // R5 restart key
    wr(A_LEN, (32'd3 << 5) | 32'h8);
    wr(A_MODE, MKEY | 32'h7);
    waitc(7);
    wr(A_RST, 32'h1970);
    waitc(3); chk("R5 wrong code ignored", {31'd0, rstOut}, 32'd0);
    waitc(1); chk("R5 original expiry", {31'd0, rstOut}, 32'd1);
    wr(A_MODE, MKEY | 32'h2);
    waitc(20);
    wr(A_MODE, MKEY | 32'h7);
    waitc(7);
    wr(A_RST, 32'h1971);
    waitc(11); chk("R5 reloaded", {31'd0, rstOut}, 32'd0);
    waitc(1);  chk("R5 new expiry", {31'd0, rstOut}, 32'd1);
    wr(A_MODE, MKEY | 32'h2);
    waitc(20);

    // R9 external reset disabled
    wr(A_MODE, MKEY | 32'h3);
    waitc(12); chk("R9 no pulse", {31'd0, rstOut}, 32'd0);
    waitc(1);  chk("R9 no pulse later", {31'd0, rstOut}, 32'd0);
    rd(A_STAT, rv); chk("R9 status timeout", rv, 32'd1);

    // R12 status clear
    wr(A_MODE, 32'h1100_0003);
    rd(A_STAT, rv); chk("R12 kept on bad key", rv, 32'd1);
    wr(A_MODE, MKEY | 32'h2);
    rd(A_STAT, rv); chk("R12 cleared", rv, 32'd0);

    // R6 software reset
    wr(A_SW, 32'h1208);
    chk("R6 wrong code", {31'd0, rstOut}, 32'd0);
    rd(A_STAT, rv); chk("R6 wrong code status", rv, 32'd0);
    wr(A_SW, 32'h1209);
    chk("R6 immediate", {31'd0, rstOut}, 32'd1);
    rd(A_STAT, rv); chk("R6 status", rv, 32'd2);
    waitc(15); chk("R8 sw pulse last", {31'd0, rstOut}, 32'd1);
    waitc(1);  chk("R8 sw pulse end", {31'd0, rstOut}, 32'd0);
    wr(A_MODE, MKEY | 32'h2);

    // R10 interrupt mode
    wr(A_MODE, MKEY | 32'hF);
    waitc(11); chk("R10 irq idle", {31'd0, irqOut}, 32'd0);
    waitc(1);  chk("R10 irq raised", {31'd0, irqOut}, 32'd1);
    chk("R10 no reset", {31'd0, rstOut}, 32'd0);
    rd(A_STAT, rv); chk("R12 irq bit", rv, 32'd4);
    waitc(12); chk("R10 second expiry no reset", {31'd0, rstOut}, 32'd0);
    chk("R10 irq held", {31'd0, irqOut}, 32'd1);
    wr(A_RST, 32'h1971);
    chk("R10 restart clears", {31'd0, irqOut}, 32'd0);
    wr(A_MODE, MKEY | 32'h2);
    waitc(20);

    // R11 dual mode
    wr(A_MODE, MKEY | 32'h4F);
    waitc(12); chk("R11 first irq", {31'd0, irqOut}, 32'd1);
    chk("R11 first no reset", {31'd0, rstOut}, 32'd0);
    waitc(11); chk("R11 before second", {31'd0, rstOut}, 32'd0);
    waitc(1);  chk("R11 second reset", {31'd0, rstOut}, 32'd1);
    rd(A_STAT, rv); chk("R11 status", rv, 32'd5);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule